// File: doc/BRIEF.md
# Sectioned Multiply-Accumulate Unit with Preload

This block multiplies two 16-bit operands and folds the 32-bit product into a 35-bit accumulator. Operand A has its own input. Operand B arrives on a 16-bit bus that it shares with the preload path of the accumulator. Each operand is captured by its own load strobe. The per-cycle controls are captured whenever either operand is loaded:

- number format: signed or unsigned;
- rounding;
- accumulate mode.

The captured controls then govern the next result update. The product is formed as signed (two's complement) or unsigned. It can be rounded by adding a one at bit 15, so that bits 31..16 form a correctly rounded 16-bit result. The result is then loaded into the accumulator, added to it, subtracted from it in the form product minus accumulator, or discarded while the accumulator holds its value.

The accumulator is read out as three sections:

| Section | Bits |
|---------|------|
| Extension | 34..32 |
| Upper | 31..16 |
| Lower | 15..0 |

Each section has a select input. With preload low, a selected section drives its output. With preload high, a selected section is instead written from the shared bus on a result-register update. The block gives the data and a drive enable for each section on separate outputs. The pad level combines them with the shared bus. Everything runs on one clock, and `rst_n` is a synchronous active-low reset.

Top module: `mac_preload_unit`

## Requirements
- R1: On a clock edge with `load_a` high, `a_in` is captured as operand A. On an edge with `load_b` high, `bus_in` is captured as operand B. An operand whose strobe is low keeps its value.
- R2: The inputs `rnd_in`, `tc_in`, `acc_in` and `sub_in` are captured on an edge where `load_a` or `load_b` is high. On all other edges they are ignored, and the next update uses the captured values.
- R3: With the captured `tc_in` = 1, both operands are two's complement and the product is sign-extended to 35 bits. With `tc_in` = 0, both operands are unsigned and the product is zero-extended.
- R4: With the captured `rnd_in` = 1, 2^15 is added to the extended product before the accumulate step. With `rnd_in` = 0, nothing is added.
- R5: Accumulate mode is selected by the captured {`acc_in`,`sub_in`}:

  | {`acc_in`,`sub_in`} | Operation |
  |---------------------|-----------|
  | 00 | Load the product |
  | 10 | Accumulator plus product |
  | 11 | Product minus accumulator |
  | 01 | Hold the accumulator |

  All operations are modulo 2^35.
- R6: The accumulator changes only on an edge with `load_r` high, or in reset.
- R7: The section outputs carry the accumulator contents at all times, whatever the selects: `x_dout` = bits 34..32, `m_dout` = bits 31..16, `l_dout` = bits 15..0.
- R8: Each drive enable (`x_drive`, `m_drive`, `l_drive`) is high exactly when its select is high and `prel` is low. With `prel` low, the selects never affect the accumulator contents.
- R9: On an edge with `load_r` and `prel` both high, each selected section is written from `bus_in`. The extension section takes `bus_in[2:0]`. Unselected sections hold their value, and no arithmetic result is stored.
- R10: When `rst_n` is low at a clock edge, the operands, the captured controls and all 35 accumulator bits become zero. A zero control word means load mode, no rounding and unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 16 | Operand A data |
| load_a | input | 1 | Capture operand A (and controls) |
| load_b | input | 1 | Capture operand B from bus_in (and controls) |
| bus_in | input | 16 | Receive side of the shared bus: operand B or preload data |
| load_r | input | 1 | Update the accumulator |
| rnd_in | input | 1 | Round request |
| tc_in | input | 1 | 1 = two's complement, 0 = unsigned |
| acc_in | input | 1 | Accumulate mode bit (high of the pair) |
| sub_in | input | 1 | Accumulate mode bit (low of the pair) |
| prel | input | 1 | Preload the selected sections instead of driving them |
| sel_x | input | 1 | Extension section select |
| sel_m | input | 1 | Upper section select |
| sel_l | input | 1 | Lower section select |
| x_dout | output | 3 | Extension section contents |
| x_drive | output | 1 | Extension section drive enable |
| m_dout | output | 16 | Upper section contents |
| m_drive | output | 1 | Upper section drive enable |
| l_dout | output | 16 | Lower section contents |
| l_drive | output | 1 | Lower section drive enable |

## Verification
A sweep covers every ordered pair from a set of twelve operand values, in both number formats and with and without rounding. The values include 0, 1, 0x7FFF, 0x8000, 0x8001, 0xFFFE and 0xFFFF. The four accumulate modes rotate across the sweep, so one accumulated total carries through all of it.

The pairs that mix most-negative and all-ones values separate sign extension from zero extension. The chained totals expose wrong operand order in subtraction and carries into the extension bits.

Directed sequences cover the remaining rules:
- controls or operands that change without a load strobe;
- idle cycles with `load_r` low;
- preload of each section alone, including the extension section taking only the low bus bits;
- drive enables under every preload state;
- a reset taken in the middle of a run.

// File: rtl/mac_pkg.sv
// Package: shared widths, accumulate mode encoding and the captured
// control word of the multiply-accumulate unit.
package mac_pkg;

    typedef enum logic [1:0] {
        MODE_LOAD = 2'd0,
        MODE_ADD  = 2'd1,
        MODE_SUB  = 2'd2,
        MODE_HOLD = 2'd3
    } acc_mode_t;

    typedef struct packed {
        logic      rnd;
        logic      tc;
        acc_mode_t mode;
    } mac_ctrl_t;

    // Map the {acc,sub} input pair to an accumulate mode.
    function automatic acc_mode_t decode_mode(input logic acc, input logic sub);
        case ({acc, sub})
            2'b10:   return MODE_ADD;
            2'b11:   return MODE_SUB;
            2'b01:   return MODE_HOLD;
            default: return MODE_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/mac_operand_stage.sv
// Operand stage: holds operands A and B and the control word captured on
// either operand strobe. Assumes a single clock and a synchronous
// active-low reset.
module mac_operand_stage
    import mac_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] a_in,
    input  logic            load_a,
    input  logic [OP_W-1:0] b_in,
    input  logic            load_b,
    input  logic            rnd_in,
    input  logic            tc_in,
    input  logic            acc_in,
    input  logic            sub_in,
    output logic [OP_W-1:0] a_q,
    output logic [OP_W-1:0] b_q,
    output mac_ctrl_t       ctrl_q
);

    logic any_load;
    assign any_load = load_a | load_b;

    // Operand A register.
    always_ff @(posedge clk) begin
        if (!rst_n)      a_q <= '0;
        else if (load_a) a_q <= a_in;
    end

    // Operand B register, fed from the shared bus.
    always_ff @(posedge clk) begin
        if (!rst_n)      b_q <= '0;
        else if (load_b) b_q <= b_in;
    end

    // Control word, captured on either operand strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (any_load) begin
            ctrl_q.rnd  <= rnd_in;
            ctrl_q.tc   <= tc_in;
            ctrl_q.mode <= decode_mode(acc_in, sub_in);
        end
    end

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_a |=> $stable(a_q)); // R1
    AST_B_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        load_b |=> b_q == $past(b_in)); // R1
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_load |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/mac_product.sv
// Product path: multiplies the held operands as signed or unsigned, extends
// the product to accumulator width and adds the optional rounding bit.
// Purely combinational; the clock and reset feed only the assertions.
module mac_product
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int EXT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [OP_W-1:0]          a_q,
    input  logic [OP_W-1:0]          b_q,
    input  mac_ctrl_t                ctrl,
    output logic [2*OP_W+EXT_W-1:0]  prod_ext
);

    localparam int ACC_W  = 2 * OP_W + EXT_W;
    localparam int FULL_W = 2 * OP_W + 2;

    logic signed [OP_W:0]     a_x, b_x;
    logic signed [FULL_W-1:0] full;
    logic [ACC_W-1:0]         rnd_word;

    // Extend each operand by one bit: a sign copy when signed, zero otherwise.
    assign a_x = {ctrl.tc & a_q[OP_W-1], a_q};
    assign b_x = {ctrl.tc & b_q[OP_W-1], b_q};

    // Full-width signed multiply; exact for both number formats.
    assign full = a_x * b_x;

    // Rounding adds one at the top bit of the lower product half.
    assign rnd_word = ACC_W'(ctrl.rnd) << (OP_W - 1);

    // Extend to accumulator width and apply the rounding increment.
    always_comb begin
        prod_ext = ACC_W'(full) + rnd_word;
        if (FULL_W < ACC_W)
            prod_ext = {{(ACC_W-FULL_W){full[FULL_W-1]}}, full} + rnd_word;
    end

    AST_UNSIGNED_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.tc |-> prod_ext[ACC_W-1:2*OP_W] == '0); // R3
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (a_q == '0) |-> prod_ext == rnd_word); // R4

endmodule

// File: rtl/mac_accum.sv
// Accumulator: a 35-bit result register built from extension, upper and
// lower sections. Each update either applies the captured accumulate mode
// or, in preload, writes the selected sections from the bus.
module mac_accum
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int EXT_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*OP_W+EXT_W-1:0]  prod_ext,
    input  acc_mode_t                mode,
    input  logic                     load_r,
    input  logic                     prel,
    input  logic [2:0]               sel,
    input  logic [OP_W-1:0]          bus_in,
    output logic [2*OP_W+EXT_W-1:0]  acc_q
);

    localparam int ACC_W = 2 * OP_W + EXT_W;
    localparam int N_SEC = 3;

    logic [ACC_W-1:0] arith_next;

    // Next arithmetic value for the captured accumulate mode.
    always_comb begin
        case (mode)
            MODE_ADD:  arith_next = acc_q + prod_ext;
            MODE_SUB:  arith_next = prod_ext - acc_q;
            MODE_HOLD: arith_next = acc_q;
            default:   arith_next = prod_ext;
        endcase
    end

    // One register per section: lower (0), upper (1), extension (2).
    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        localparam int W   = (g == N_SEC - 1) ? EXT_W : OP_W;
        localparam int LSB = g * OP_W;
        logic [W-1:0] sec_q;

        // Section update from reset, preload or the arithmetic path.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sec_q <= '0;
            end else if (load_r) begin
                if (prel) begin
                    if (sel[g]) sec_q <= bus_in[W-1:0];
                end else begin
                    sec_q <= arith_next[LSB +: W];
                end
            end
        end

        assign acc_q[LSB +: W] = sec_q;
    end

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load_r |=> $stable(acc_q)); // R6
    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_r && !prel && mode == MODE_HOLD) |=> $stable(acc_q)); // R5
    AST_LOAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_r && !prel && mode == MODE_LOAD) |=> acc_q == $past(prod_ext)); // R5
    AST_PRELOAD_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_r && prel && sel[2]) |=> acc_q[ACC_W-1:2*OP_W] == $past(bus_in[EXT_W-1:0])); // R9
    AST_PRELOAD_KEEP_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (load_r && prel && !sel[1]) |=> $stable(acc_q[2*OP_W-1:OP_W])); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> acc_q == '0); // R10

endmodule

// File: rtl/mac_preload_unit.sv
// Top: sectioned multiply-accumulate unit. Wires the operand stage, the
// product path and the accumulator, and derives a drive enable for each
// section. The shared bus is split into a receive side (bus_in) and a
// transmit side (the section outputs); the pads combine them outside.
module mac_preload_unit
    import mac_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int EXT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  a_in,
    input  logic             load_a,
    input  logic             load_b,
    input  logic [OP_W-1:0]  bus_in,
    input  logic             load_r,
    input  logic             rnd_in,
    input  logic             tc_in,
    input  logic             acc_in,
    input  logic             sub_in,
    input  logic             prel,
    input  logic             sel_x,
    input  logic             sel_m,
    input  logic             sel_l,
    output logic [EXT_W-1:0] x_dout,
    output logic             x_drive,
    output logic [OP_W-1:0]  m_dout,
    output logic             m_drive,
    output logic [OP_W-1:0]  l_dout,
    output logic             l_drive
);

    localparam int ACC_W = 2 * OP_W + EXT_W;

    logic [OP_W-1:0]  a_q, b_q;
    mac_ctrl_t        ctrl_q;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_q;
    logic [2:0]       sel;

    assign sel = {sel_x, sel_m, sel_l};

    mac_operand_stage #(.OP_W(OP_W)) i_operands (
        .clk    (clk),
        .rst_n  (rst_n),
        .a_in   (a_in),
        .load_a (load_a),
        .b_in   (bus_in),
        .load_b (load_b),
        .rnd_in (rnd_in),
        .tc_in  (tc_in),
        .acc_in (acc_in),
        .sub_in (sub_in),
        .a_q    (a_q),
        .b_q    (b_q),
        .ctrl_q (ctrl_q)
    );

    mac_product #(.OP_W(OP_W), .EXT_W(EXT_W)) i_product (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_q      (a_q),
        .b_q      (b_q),
        .ctrl     (ctrl_q),
        .prod_ext (prod_ext)
    );

    mac_accum #(.OP_W(OP_W), .EXT_W(EXT_W)) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .prod_ext (prod_ext),
        .mode     (ctrl_q.mode),
        .load_r   (load_r),
        .prel     (prel),
        .sel      (sel),
        .bus_in   (bus_in),
        .acc_q    (acc_q)
    );

    // Section contents are always presented; drive follows select unless preloading.
    assign x_dout  = acc_q[ACC_W-1:2*OP_W];
    assign m_dout  = acc_q[2*OP_W-1:OP_W];
    assign l_dout  = acc_q[OP_W-1:0];
    assign x_drive = sel_x & ~prel;
    assign m_drive = sel_m & ~prel;
    assign l_drive = sel_l & ~prel;

    AST_NO_DRIVE_IN_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        prel |-> !(x_drive || m_drive || l_drive)); // R8
    AST_SELECT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (load_r && !prel && ctrl_q.mode == MODE_LOAD) |=>
        {x_dout, m_dout, l_dout} == $past(prod_ext)); // R8

endmodule

// File: tb/test_mac_preload_unit.sv
// Bench: sweeps operand pairs, formats, rounding and modes against an
// arithmetic model, then runs directed sequences for capture, preload,
// drive enables and reset.
module test_mac_preload_unit;

    localparam longint MASK35 = 64'h7_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_in = '0, bus_in = '0;
    logic        load_a = 0, load_b = 0, load_r = 0;
    logic        rnd_in = 0, tc_in = 0, acc_in = 0, sub_in = 0;
    logic        prel = 0, sel_x = 1, sel_m = 1, sel_l = 1;
    logic [2:0]  x_dout;
    logic [15:0] m_dout, l_dout;
    logic        x_drive, m_drive, l_drive;

    int     checks = 0;
    int     errors = 0;
    longint model  = 0;
    bit     done   = 0;

    always #5 clk = ~clk;

    mac_preload_unit i_mac_preload_unit (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .load_a(load_a), .load_b(load_b),
        .bus_in(bus_in), .load_r(load_r), .rnd_in(rnd_in), .tc_in(tc_in),
        .acc_in(acc_in), .sub_in(sub_in), .prel(prel), .sel_x(sel_x),
        .sel_m(sel_m), .sel_l(sel_l), .x_dout(x_dout), .x_drive(x_drive),
        .m_dout(m_dout), .m_drive(m_drive), .l_dout(l_dout), .l_drive(l_drive)
    );

    function automatic longint to_val(input logic [15:0] v, input bit tc);
        if (tc && v[15]) return longint'(v) - 65536;
        return longint'(v);
    endfunction

    function automatic longint product(input logic [15:0] a, input logic [15:0] b,
                                       input bit tc, input bit rnd);
        return (to_val(a, tc) * to_val(b, tc) + (rnd ? 32768 : 0)) & MASK35;
    endfunction

    // Accumulate model: mode from {acc,sub}.
    function automatic longint step(input longint acc, input longint p,
                                    input bit ac, input bit sb);
        case ({ac, sb})
            2'b10:   return (acc + p) & MASK35;
            2'b11:   return (p - acc) & MASK35;
            2'b01:   return acc;
            default: return p;
        endcase
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic longint acc_now();
        return longint'({x_dout, m_dout, l_dout});
    endfunction

    // Load operands and controls, then update the accumulator; ends at a negedge.
    task automatic do_op(input logic [15:0] a, input logic [15:0] b,
                         input bit tc, input bit rnd, input bit ac, input bit sb);
        a_in = a; bus_in = b; tc_in = tc; rnd_in = rnd; acc_in = ac; sub_in = sb;
        load_a = 1; load_b = 1;
        @(negedge clk);
        load_a = 0; load_b = 0; load_r = 1;
        @(negedge clk);
        load_r = 0;
        model = step(model, product(a, b, tc, rnd), ac, sb);
    endtask

    task automatic preload(input bit sx, input bit sm, input bit sl, input logic [15:0] d);
        prel = 1; sel_x = sx; sel_m = sm; sel_l = sl; bus_in = d; load_r = 1;
        @(negedge clk);
        load_r = 0;
        check("R8 drive off in preload", longint'({x_drive, m_drive, l_drive}), 0);
        prel = 0; sel_x = 1; sel_m = 1; sel_l = 1;
        if (sx) model = (model & ~(64'h7 << 32)) | ((longint'(d) & 7) << 32);
        if (sm) model = (model & ~(64'hFFFF << 16)) | (longint'(d) << 16);
        if (sl) model = (model & ~64'hFFFF) | longint'(d);
    endtask

    initial begin
        logic [15:0] vals [12];
        vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'h8001,
                 16'hFFFF, 16'hFFFE, 16'h1234, 16'hABCD, 16'h00FF, 16'h5555};
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R10 reset clears accumulator", acc_now(), 0);
        check("R8 drive with select and no preload", longint'({x_drive, m_drive, l_drive}), 7);

        // Sweep: R3 format, R4 rounding, R5 modes, R7 section split.
        begin
            int n = 0;
            for (int t = 0; t < 2; t++)
                for (int r = 0; r < 2; r++)
                    for (int i = 0; i < 12; i++)
                        for (int j = 0; j < 12; j++) begin
                            int m = n % 4;
                            do_op(vals[i], vals[j], t[0], r[0], m[1], m[0]);
                            check(t ? "R3 R5 signed sweep" : "R4 R5 unsigned sweep",
                                  acc_now(), model);
                            n++;
                        end
        end

        // R5: the most negative square loaded, subtracted, then held.
        do_op(16'h8000, 16'h8000, 1, 0, 0, 0);
        check("R5 load", acc_now(), 64'h0_4000_0000);
        do_op(16'h0001, 16'h0001, 1, 0, 1, 1);
        check("R5 product minus accumulator", acc_now(), model);
        do_op(16'h1111, 16'h2222, 0, 1, 0, 1);
        check("R5 hold mode", acc_now(), model);

        // R2: controls changed without a strobe are ignored.
        do_op(16'h00FF, 16'h0101, 0, 0, 0, 0);
        rnd_in = 1; acc_in = 1; sub_in = 0; load_r = 1;
        @(negedge clk);
        load_r = 0;
        check("R2 controls ignored without strobe", acc_now(), product(16'h00FF, 16'h0101, 0, 0));

        // R1: operand inputs changed without strobes are ignored.
        a_in = 16'hFFFF; bus_in = 16'hFFFF; load_r = 1;
        @(negedge clk);
        load_r = 0;
        check("R1 operands held", acc_now(), product(16'h00FF, 16'h0101, 0, 0));
        model = product(16'h00FF, 16'h0101, 0, 0);

        // R6: no update while load_r is low.
        load_a = 1; load_b = 1; a_in = 16'h4444; bus_in = 16'h5555; acc_in = 1;
        @(negedge clk);
        load_a = 0; load_b = 0;
        repeat (3) @(negedge clk);
        check("R6 idle cycles", acc_now(), model);

        // R9: preload each section alone; extension takes bus bits 2..0.
        preload(1, 0, 0, 16'hFFFD);
        check("R9 extension preload", acc_now(), model);
        check("R9 extension low bits", longint'(x_dout), 5);
        preload(0, 1, 0, 16'hBEEF);
        check("R9 upper preload", acc_now(), model);
        preload(0, 0, 1, 16'hCAFE);
        check("R9 lower preload", acc_now(), model);
        preload(0, 0, 0, 16'h1357);
        check("R9 no select no change", acc_now(), model);

        // R8: deselected without preload: no drive, arithmetic still stored.
        sel_x = 0; sel_m = 0; sel_l = 0;
        @(negedge clk);
        check("R8 deselected no drive", longint'({x_drive, m_drive, l_drive}), 0);
        do_op(16'h7FFF, 16'h7FFF, 1, 1, 1, 0);
        check("R8 selects do not gate contents", acc_now(), model);
        sel_x = 1; sel_m = 1; sel_l = 1;

        // R10: mid-run reset clears operands and controls too.
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R10 mid-run reset", acc_now(), 0);
        a_in = 16'h9999; bus_in = 16'h9999; load_r = 1;
        @(negedge clk);
        load_r = 0;
        check("R10 operands and controls cleared", acc_now(), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule